// File: doc/BRIEF.md
# Coarse/Fine Tuning PWM DAC

This block produces one pulse-width-modulated line for voltage-synthesized tuning, with 14 bits of resolution. A 3:1 prescaler derives a tick from the core clock. A free-running 14-bit tick counter is split into two parts. The upper 7 bits number 128 sub-periods, and the lower 7 bits give the tick position inside the current sub-period.

A coarse setting fixes the low time at the start of every sub-period. A fine setting adds single-tick pulses at the start of chosen sub-periods. The bits of the fine setting are active low and binary weighted, so the extra pulses spread evenly over the full cycle. After an external RC filter, the line therefore carries a level of roughly (sub-period high time × 128 + extra pulses) / 16384.

Software writes the coarse holding register first and the fine holding register second. The fine write arms a transfer. At the next sub-period start, both holding registers move together into the working pair that drives the waveform. This ensures the waveform never shows a half-updated setting.

Top module: `tune_pwm_dac`

## Requirements
- R1: A tick occurs once every 3 clock cycles. The 14-bit counter advances by one per tick, starting from 0 after reset. Position = counter[6:0] and sub-period = counter[13:7].
- R2: Inside each sub-period, the base waveform is low while position ≤ coarse, which lasts coarse+1 ticks. It is high for the rest of the sub-period. A coarse value of 127 keeps the base waveform low throughout.
- R3: Fine bit k (0..6) at value 0 adds a one-tick high pulse at position 0 of every sub-period n ≠ 0 whose count of trailing zero bits equals 6−k. With k=0 this is sub-period 64, and with k=6 it is every odd sub-period. Sub-period 0 never receives an extra pulse.
- R4: When several fine bits are 0, the extra pulses from all of their groups appear together. Each extra pulse is ORed onto the base waveform.
- R5: A write to either holding register changes nothing on dac_o until a transfer takes place.
- R6: A fine write raises pending_o in the next cycle. At the first sub-period start after that, both holding registers are copied into the working pair, and pending_o falls in the same cycle.
- R7: If a fine write is sampled in the same cycle as a sub-period start, the transfer waits for the following sub-period start, and pending_o stays high.
- R8: With pol_i = 1, dac_o equals the waveform. With pol_i = 0, dac_o is its inverse.
- R9: Reset clears the counter, the holding registers, the working pair and the pending flag. With pol_i = 1, dac_o is then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coarse_wr_i | input | 1 | Write strobe for the coarse holding register |
| coarse_i | input | 7 | Coarse value |
| fine_wr_i | input | 1 | Write strobe for the fine holding register; arms the transfer |
| fine_i | input | 7 | Fine value, active-low group enables |
| pol_i | input | 1 | 1: normal output, 0: inverted output |
| dac_o | output | 1 | PWM output |
| pending_o | output | 1 | A transfer is armed and has not yet occurred |

## Verification
The clash that needs care is a fine write sampled on the same clock edge on which the counter rolls into a new sub-period. At that edge, the write arms a transfer while the boundary tries to complete the previous one. The bench tracks the edge count after reset and places the fine strobe exactly on a sub-period rollover. It then expects pending_o to remain high and the working pair to keep its old setting for one more full sub-period. Every other cycle is compared against a behavioural model that derives the counter from the clock count and computes the expected level from the tick position, the sub-period's trailing zeros and the polarity.

// File: rtl/tdac_pkg.sv
package tdac_pkg;
  localparam int unsigned TDAC_DIV   = 3;
  localparam int unsigned TDAC_CNT_W = 14;
  localparam int unsigned TDAC_SUB_W = 7;
endpackage

// File: rtl/tdac_timebase.sv
module tdac_timebase #(
  parameter int unsigned DIV   = 3,
  parameter int unsigned CNT_W = 14,
  parameter int unsigned SUB_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             tick_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sub_start_o
);
  localparam int unsigned POS_W = CNT_W - SUB_W;
  localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (div_q == DIV_W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (tick_o) begin
      div_q <= '0;
      cnt_q <= cnt_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  // next edge rolls position to 0
  assign sub_start_o = tick_o && (&cnt_q[POS_W-1:0]);

  p_cnt_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  p_cnt_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(cnt_q));
endmodule

// File: rtl/tdac_loader.sv
module tdac_loader #(
  parameter int unsigned POS_W = 7,
  parameter int unsigned SUB_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             coarse_wr_i,
  input  logic [POS_W-1:0] coarse_i,
  input  logic             fine_wr_i,
  input  logic [SUB_W-1:0] fine_i,
  input  logic             sub_start_i,
  output logic [POS_W-1:0] coarse_o,
  output logic [SUB_W-1:0] fine_o,
  output logic             pending_o
);
  logic [POS_W-1:0] hold_c_q, work_c_q;
  logic [SUB_W-1:0] hold_f_q, work_f_q;
  logic             pend_q;
  logic             xfer;

  assign xfer = sub_start_i && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_c_q <= '0;
      hold_f_q <= '0;
      work_c_q <= '0;
      work_f_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (coarse_wr_i) hold_c_q <= coarse_i;
      if (fine_wr_i)   hold_f_q <= fine_i;
      if (xfer) begin
        work_c_q <= hold_c_q;
        work_f_q <= hold_f_q;
      end
      // a write on the boundary re-arms for the next one
      if (fine_wr_i)        pend_q <= 1'b1;
      else if (sub_start_i) pend_q <= 1'b0;
    end
  end

  assign coarse_o  = work_c_q;
  assign fine_o    = work_f_q;
  assign pending_o = pend_q;

  p_work_only_at_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sub_start_i && pending_o) |=> $stable(coarse_o) && $stable(fine_o));
  p_load_value_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_start_i && pending_o |=> coarse_o == $past(hold_c_q) && fine_o == $past(hold_f_q));
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_start_i && pending_o && !fine_wr_i |=> !pending_o);
  p_defer_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_wr_i |=> pending_o);
endmodule

// File: rtl/tdac_shaper.sv
module tdac_shaper #(
  parameter int unsigned CNT_W = 14,
  parameter int unsigned SUB_W = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [CNT_W-1:0]         cnt_i,
  input  logic [CNT_W-SUB_W-1:0]   coarse_i,
  input  logic [SUB_W-1:0]         fine_i,
  input  logic                     pol_i,
  output logic                     dac_o
);
  localparam int unsigned POS_W = CNT_W - SUB_W;

  logic [POS_W-1:0] pos;
  logic [SUB_W-1:0] sub;
  logic [SUB_W-1:0] grp_hit;
  logic             extra, base, raw;

  assign pos = cnt_i[POS_W-1:0];
  assign sub = cnt_i[CNT_W-1:POS_W];

  // group k: sub-periods whose trailing-zero count is SUB_W-1-k
  for (genvar k = 0; k < SUB_W; k++) begin : g_grp
    localparam logic [SUB_W-1:0] MSK = SUB_W'((1 << (SUB_W - k)) - 1);
    localparam logic [SUB_W-1:0] ONE = SUB_W'(1 << (SUB_W - 1 - k));
    assign grp_hit[k] = ((sub & MSK) == ONE);
  end

  assign extra = (pos == '0) && |(grp_hit & ~fine_i);
  assign base  = (pos > coarse_i);
  assign raw   = base | extra;
  assign dac_o = pol_i ? raw : ~raw;

  p_cycle_start_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |-> !raw);
  p_coarse_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos != '0) && (pos <= coarse_i) |-> !raw);
endmodule

// File: rtl/tune_pwm_dac.sv
module tune_pwm_dac
  import tdac_pkg::*;
#(
  parameter int unsigned DIV   = TDAC_DIV,
  parameter int unsigned CNT_W = TDAC_CNT_W,
  parameter int unsigned SUB_W = TDAC_SUB_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   coarse_wr_i,
  input  logic [CNT_W-SUB_W-1:0] coarse_i,
  input  logic                   fine_wr_i,
  input  logic [SUB_W-1:0]       fine_i,
  input  logic                   pol_i,
  output logic                   dac_o,
  output logic                   pending_o
);
  localparam int unsigned POS_W = CNT_W - SUB_W;

  logic             tick;
  logic             sub_start;
  logic [CNT_W-1:0] cnt;
  logic [POS_W-1:0] work_c;
  logic [SUB_W-1:0] work_f;

  tdac_timebase #(.DIV(DIV), .CNT_W(CNT_W), .SUB_W(SUB_W)) u_timebase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_o      (tick),
    .cnt_o       (cnt),
    .sub_start_o (sub_start)
  );

  tdac_loader #(.POS_W(POS_W), .SUB_W(SUB_W)) u_loader (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .coarse_wr_i (coarse_wr_i),
    .coarse_i    (coarse_i),
    .fine_wr_i   (fine_wr_i),
    .fine_i      (fine_i),
    .sub_start_i (sub_start),
    .coarse_o    (work_c),
    .fine_o      (work_f),
    .pending_o   (pending_o)
  );

  tdac_shaper #(.CNT_W(CNT_W), .SUB_W(SUB_W)) u_shaper (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_i    (cnt),
    .coarse_i (work_c),
    .fine_i   (work_f),
    .pol_i    (pol_i),
    .dac_o    (dac_o)
  );

  p_start_only_on_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_start |-> tick);
endmodule

// File: tb/tune_pwm_dac_test.sv
`timescale 1ns/1ps
module tune_pwm_dac_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       coarse_wr = 1'b0, fine_wr = 1'b0, pol = 1'b1;
  logic [6:0] coarse_d = '0, fine_d = '0;
  logic       dac_o, pending_o;

  int checks = 0, errors = 0;
  bit en = 0, done = 0;
  string cur_tag = "R9";

  always #4 clk = ~clk;

  tune_pwm_dac uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .coarse_wr_i(coarse_wr), .coarse_i(coarse_d),
    .fine_wr_i(fine_wr), .fine_i(fine_d),
    .pol_i(pol), .dac_o(dac_o), .pending_o(pending_o)
  );

  // behavioural model
  int m_edges, m_cnt, m_hc, m_hf, m_wc, m_wf;
  bit m_pend;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_edges = 0; m_cnt = 0; m_hc = 0; m_hf = 0; m_wc = 0; m_wf = 0; m_pend = 0;
    end else begin
      int nc;
      bit bnd;
      m_edges++;
      nc  = (m_edges / 3) % 16384;
      bnd = (m_edges % 3 == 0) && (nc % 128 == 0);
      if (bnd && m_pend) begin m_wc = m_hc; m_wf = m_hf; end
      if (fine_wr) m_pend = 1;
      else if (bnd) m_pend = 0;
      if (coarse_wr) m_hc = coarse_d;
      if (fine_wr)   m_hf = fine_d;
      m_cnt = nc;
    end
  end

  function automatic bit exp_dac();
    int pos = m_cnt % 128;
    int sub = m_cnt / 128;
    int tz = 0;
    bit raw, extra = 0;
    if (pos == 0 && sub != 0) begin
      int s = sub;
      while (s % 2 == 0) begin s = s / 2; tz++; end
      extra = ((m_wf >> (6 - tz)) & 1) == 0;
    end
    raw = (pos > m_wc) || extra;
    return pol ? raw : !raw;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at edge %0d", tag, act, exp, m_edges);
    end
  endtask

  always @(negedge clk) if (en && !done) begin
    check(cur_tag, dac_o, exp_dac());
    check("R6", pending_o, m_pend);
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr_coarse(logic [6:0] v);
    @(posedge clk); #2; coarse_wr = 1; coarse_d = v;
    @(posedge clk); #2; coarse_wr = 0;
  endtask

  task automatic wr_fine(logic [6:0] v);
    @(posedge clk); #2; fine_wr = 1; fine_d = v;
    @(posedge clk); #2; fine_wr = 0;
  endtask

  task automatic wait_mod(int r);
    do begin @(posedge clk); #2; end while (m_edges % 384 != r);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #30;
    check("R9", dac_o, 1'b0);
    check("R9", pending_o, 1'b0);
    @(posedge clk); #2; rst_ni = 1; en = 1;
    cur_tag = "R1"; step(400);
    cur_tag = "R5"; wr_coarse(7'd20); step(200);
    check("R5", pending_o, 1'b0);
    cur_tag = "R6"; wr_fine(7'h7E);
    check("R6", pending_o, 1'b1);
    while (pending_o) step(1);
    step(400);
    // fine write sampled on a sub-period rollover edge
    cur_tag = "R7"; wait_mod(383);
    fine_wr = 1; fine_d = 7'h7D;
    @(posedge clk); #2; fine_wr = 0;
    @(negedge clk);
    check("R7", pending_o, 1'b1);
    step(500);
    cur_tag = "R2"; wr_coarse(7'd127); wr_fine(7'h7F); step(900);
    wr_coarse(7'd0); wr_fine(7'h7F); step(900);
    wr_coarse(7'd5); wr_fine(7'h7F); step(900);
    cur_tag = "R3"; wr_coarse(7'd90); wr_fine(7'h3F); step(64 * 384);
    wr_fine(7'h7B); step(16 * 384);
    cur_tag = "R4"; wr_coarse(7'd33); wr_fine(7'b1111010); step(49152 + 400);
    cur_tag = "R8"; pol = 0; wr_fine(7'h5B); step(1200);
    finish_run();
  end
endmodule